// File: doc/BRIEF.md
# Interrupt Aggregation and Soft-Reset Register Unit

This unit collects eight single-cycle event pulses from a serial-bus peripheral core into one interrupt request line. Each event is caught in a sticky status bit. A status bit reaches the line only when two conditions hold: its own enable bit is set, and a single global enable bit is set. Software clears a status bit by writing a one to that bit position. The line is driven from a flop.

The same register port also carries a soft-reset register. Writing one exact key value to it starts a core reset pulse of fixed length. The pulse also returns the status, enable and global-enable registers to zero. Any other value written to the reset register is refused and reported on an error strobe.

The register port is a plain 32-bit port with a byte address, a write strobe and write data. Read data is combinational from the address and has no side effects. Bus protocol adapters sit outside this block.

Top module: `intr_agg_unit`

## Requirements
- R1: After `rst_n` is deasserted, every register reads zero and `irq_out`, `core_rst` and `key_err` are low.
- R2: A high `src_evt[k]` at a clock edge sets status bit k. The status register is at byte offset 0x20 and holds its bits in [7:0], in this order from bit 0 up: arbitration lost, transmit error, transmit FIFO empty, receive level reached, bus idle, selected as target, deselected as target, transmit FIFO half empty. The bit stays set, and reading the register never changes it.
- R3: A write to offset 0x20 clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When an event for bit k arrives at the same edge as a clearing write to bit k, bit k ends up set. Other bits in the same write are still cleared.
- R5: `irq_out` is a registered version of the OR of (status AND enable), gated by the global enable. It goes high one edge after the status bit becomes visible, and goes low one edge after the last pending bit is cleared or masked.
- R6: The enable register is at offset 0x28. Bits [7:0] can be written and read back; bits [31:8] read zero.
- R7: The global enable register is at offset 0x1C. Only bit 31 is stored; every other bit reads zero.
- R8: Writing exactly 0x0000000A to offset 0x40 drives `core_rst` high for exactly 16 consecutive cycles, starting at the edge that takes the write.
- R9: The key write clears status, enable, global enable and `irq_out`. While `core_rst` is high, events and register writes have no effect.
- R10: A write of any other value to offset 0x40 raises `key_err` for one cycle and starts no reset. All registers keep their values.
- R11: Reads of unmapped offsets, and of the reset register, return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address for read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| src_evt | input | 8 | Event pulses, one per source |
| irq_out | output | 1 | Registered interrupt request |
| core_rst | output | 1 | Soft-reset pulse to the peripheral core |
| key_err | output | 1 | One-cycle strobe for a rejected reset write |

## Verification
The hardest case to reach is the collision between an incoming event and a write-one-to-clear on the same bit in the same cycle. In that case the event must win, while the other bits named in the same write are still cleared. The bench pre-sets one status bit, then drives the event and the clearing write at the same negative edge, so both land on one rising edge. A second hard case is stimulus arriving during the reset pulse. The bench pulses every source and writes the enables in the middle of the 16-cycle window, then reads back zeros after the pulse ends.

// File: rtl/intr_agg_pkg.sv
package intr_agg_pkg;

   // Register selected by the current byte address
   typedef enum logic [2:0] {
      SEL_NONE = 3'd0,
      SEL_GIE  = 3'd1,
      SEL_STAT = 3'd2,
      SEL_EN   = 3'd3,
      SEL_RST  = 3'd4
   } reg_sel_e;

   // Source positions; the order sets the bit position in status and enable
   localparam int SRC_ARB_LOST   = 0;
   localparam int SRC_TX_ERR     = 1;
   localparam int SRC_TX_EMPTY   = 2;
   localparam int SRC_RX_LEVEL   = 3;
   localparam int SRC_BUS_IDLE   = 4;
   localparam int SRC_TGT_SEL    = 5;
   localparam int SRC_TGT_DESEL  = 6;
   localparam int SRC_TX_HALF    = 7;

endpackage

// File: rtl/intr_reg_decode.sv
module intr_reg_decode
   import intr_agg_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int OFS_GIE  = 'h1C,
   parameter int OFS_STAT = 'h20,
   parameter int OFS_EN   = 'h28,
   parameter int OFS_RST  = 'h40
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);

   localparam logic [ADDR_W-1:0] A_GIE  = OFS_GIE[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_STAT = OFS_STAT[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_EN   = OFS_EN[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_RST  = OFS_RST[ADDR_W-1:0];

   always_comb begin
      sel = SEL_NONE;
      if (addr == A_GIE)       sel = SEL_GIE;
      else if (addr == A_STAT) sel = SEL_STAT;
      else if (addr == A_EN)   sel = SEL_EN;
      else if (addr == A_RST)  sel = SEL_RST;
   end

endmodule

// File: rtl/intr_status_bank.sv
module intr_status_bank #(
   parameter int N_SRC = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_all,
   input  logic [N_SRC-1:0] evt,
   input  logic             clr_we,
   input  logic [N_SRC-1:0] clr_mask,
   output logic [N_SRC-1:0] stat_q
);

   for (genvar i = 0; i < N_SRC; i++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     bit_q <= 1'b0;
         else if (clr_all)               bit_q <= 1'b0;
         else if (evt[i])                bit_q <= 1'b1;   // event beats clear
         else if (clr_we && clr_mask[i]) bit_q <= 1'b0;
      end
      assign stat_q[i] = bit_q;
   end

endmodule

// File: rtl/intr_soft_reset.sv
module intr_soft_reset #(
   parameter int                DATA_W     = 32,
   parameter int                RST_CYCLES = 16,
   parameter logic [DATA_W-1:0] RST_KEY    = 'hA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   output logic              key_hit,
   output logic              core_rst,
   output logic              key_err
);

   localparam int CNT_W = $clog2(RST_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES);

   logic [CNT_W-1:0] cnt_q;
   logic             err_q;
   logic             bad_key;

   assign core_rst = (cnt_q != '0);
   assign key_hit  = wr_stb && !core_rst && (wr_data == RST_KEY);
   assign bad_key  = wr_stb && !core_rst && (wr_data != RST_KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (key_hit)      cnt_q <= CNT_LOAD;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= bad_key;
   end

   assign key_err = err_q;

endmodule

// File: rtl/intr_agg_unit.sv
module intr_agg_unit
   import intr_agg_pkg::*;
#(
   parameter int                N_SRC      = 8,
   parameter int                DATA_W     = 32,
   parameter int                ADDR_W     = 8,
   parameter int                GIE_BIT    = 31,
   parameter int                RST_CYCLES = 16,
   parameter logic [DATA_W-1:0] RST_KEY    = 'hA,
   parameter int                OFS_GIE    = 'h1C,
   parameter int                OFS_STAT   = 'h20,
   parameter int                OFS_EN     = 'h28,
   parameter int                OFS_RST    = 'h40,
   parameter bit                REG_IRQ    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic [N_SRC-1:0]  src_evt,
   output logic              irq_out,
   output logic              core_rst,
   output logic              key_err
);

   // elaboration-time parameter checks
   if (N_SRC < 1 || N_SRC > DATA_W) begin : g_chk_nsrc
      $error("N_SRC must lie in 1..DATA_W");
   end
   if (GIE_BIT < 0 || GIE_BIT >= DATA_W) begin : g_chk_gie
      $error("GIE_BIT outside the data word");
   end
   if (RST_CYCLES < 1) begin : g_chk_len
      $error("RST_CYCLES must be at least 1");
   end
   if ((1 << ADDR_W) <= OFS_RST || (1 << ADDR_W) <= OFS_EN) begin : g_chk_addr
      $error("ADDR_W too narrow for the register offsets");
   end

   reg_sel_e         sel;
   logic             wr_ok;
   logic             key_hit;
   logic             clr_all;
   logic [N_SRC-1:0] stat_q;
   logic [N_SRC-1:0] en_q;
   logic             gie_q;
   logic             irq_any;

   intr_reg_decode #(
      .ADDR_W   (ADDR_W),
      .OFS_GIE  (OFS_GIE),
      .OFS_STAT (OFS_STAT),
      .OFS_EN   (OFS_EN),
      .OFS_RST  (OFS_RST)
   ) u_dec (
      .addr (addr),
      .sel  (sel)
   );

   intr_soft_reset #(
      .DATA_W     (DATA_W),
      .RST_CYCLES (RST_CYCLES),
      .RST_KEY    (RST_KEY)
   ) u_srst (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (wr_en && (sel == SEL_RST)),
      .wr_data  (wr_data),
      .key_hit  (key_hit),
      .core_rst (core_rst),
      .key_err  (key_err)
   );

   assign wr_ok   = wr_en && !core_rst;
   assign clr_all = key_hit || core_rst;

   intr_status_bank #(
      .N_SRC (N_SRC)
   ) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_all  (clr_all),
      .evt      (src_evt),
      .clr_we   (wr_ok && (sel == SEL_STAT)),
      .clr_mask (wr_data[N_SRC-1:0]),
      .stat_q   (stat_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        en_q <= '0;
      else if (clr_all)                  en_q <= '0;
      else if (wr_ok && sel == SEL_EN)   en_q <= wr_data[N_SRC-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        gie_q <= 1'b0;
      else if (clr_all)                  gie_q <= 1'b0;
      else if (wr_ok && sel == SEL_GIE)  gie_q <= wr_data[GIE_BIT];
   end

   assign irq_any = gie_q && (|(stat_q & en_q));

   if (REG_IRQ) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       irq_q <= 1'b0;
         else if (clr_all) irq_q <= 1'b0;
         else              irq_q <= irq_any;
      end
      assign irq_out = irq_q;
   end else begin : g_irq_comb
      assign irq_out = irq_any;
   end

   always_comb begin
      rd_data = '0;
      case (sel)
         SEL_GIE:  rd_data[GIE_BIT]     = gie_q;
         SEL_STAT: rd_data[N_SRC-1:0]   = stat_q;
         SEL_EN:   rd_data[N_SRC-1:0]   = en_q;
         default:  rd_data              = '0;
      endcase
   end

endmodule

// File: rtl/intr_agg_chk.sv
module intr_agg_chk #(
   parameter int N_SRC      = 8,
   parameter int ADDR_W     = 8,
   parameter int RST_CYCLES = 16,
   parameter int OFS_STAT   = 'h20,
   parameter int OFS_RST    = 'h40,
   parameter bit REG_IRQ    = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [N_SRC-1:0]  src_evt,
   input logic [N_SRC-1:0]  stat_q,
   input logic [N_SRC-1:0]  en_q,
   input logic              gie_q,
   input logic              irq_out,
   input logic              core_rst,
   input logic              key_err
);

   localparam int RUN_W = $clog2(RST_CYCLES + 2) + 1;

   logic [RUN_W-1:0] run_cnt;
   logic             rst_wr;
   logic             stat_wr;

   assign rst_wr  = wr_en && (addr == OFS_RST[ADDR_W-1:0]);
   assign stat_wr = wr_en && (addr == OFS_STAT[ADDR_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        run_cnt <= '0;
      else if (!core_rst) run_cnt <= '0;
      else               run_cnt <= run_cnt + 1'b1;
   end

   AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ((|src_evt) && !core_rst && !rst_wr) |=> ((stat_q & $past(src_evt)) == $past(src_evt))); // R4

   AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_rst && !rst_wr && !stat_wr) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R3

   AST_RST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_rst) |-> (run_cnt == RUN_W'(RST_CYCLES))); // R8

   AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst |-> (stat_q == '0 && en_q == '0 && !gie_q && !irq_out)); // R9

   AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      key_err |-> !core_rst); // R10

   if (REG_IRQ) begin : g_irq_props
      AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
         irq_out |-> $past(gie_q)); // R5

      AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(|(stat_q & en_q)) |-> !irq_out); // R5
   end

endmodule

bind intr_agg_unit intr_agg_chk #(
   .N_SRC      (N_SRC),
   .ADDR_W     (ADDR_W),
   .RST_CYCLES (RST_CYCLES),
   .OFS_STAT   (OFS_STAT),
   .OFS_RST    (OFS_RST),
   .REG_IRQ    (REG_IRQ)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .addr     (addr),
   .src_evt  (src_evt),
   .stat_q   (stat_q),
   .en_q     (en_q),
   .gie_q    (gie_q),
   .irq_out  (irq_out),
   .core_rst (core_rst),
   .key_err  (key_err)
);

// File: tb/tb_intr_agg_unit.sv
module tb_intr_agg_unit;

   localparam int CLK_P = 10;
   localparam logic [7:0] A_GIE  = 8'h1C;
   localparam logic [7:0] A_STAT = 8'h20;
   localparam logic [7:0] A_EN   = 8'h28;
   localparam logic [7:0] A_RST  = 8'h40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [7:0]  src_evt = '0;
   logic        irq_out;
   logic        core_rst;
   logic        key_err;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   intr_agg_unit dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (addr),
      .wr_data  (wr_data),
      .rd_data  (rd_data),
      .src_evt  (src_evt),
      .irq_out  (irq_out),
      .core_rst (core_rst),
      .key_err  (key_err)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
      addr = a; #1;
      check(req, rd_data, exp);
   endtask

   task automatic pulse(input logic [7:0] m);
      @(negedge clk);
      src_evt = m;
      @(posedge clk); #1;
      src_evt = '0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
      end
   endtask

   task automatic t_reset_state();
      rd_chk("R1 status", A_STAT, 32'h0);
      rd_chk("R1 enable", A_EN, 32'h0);
      rd_chk("R1 gie", A_GIE, 32'h0);
      check("R1 irq_out", {31'b0, irq_out}, 32'h0);
      check("R1 core_rst", {31'b0, core_rst}, 32'h0);
      check("R1 key_err", {31'b0, key_err}, 32'h0);
   endtask

   task automatic t_sticky();
      pulse(8'h12);
      rd_chk("R2 status after pulse", A_STAT, 32'h12);
      idle(3);
      rd_chk("R2 status sticky", A_STAT, 32'h12);
      rd_chk("R2 read has no side effect", A_STAT, 32'h12);
      pulse(8'h01);   // arbitration-lost bit is bit 0
      rd_chk("R2 bit0 accumulates", A_STAT, 32'h13);
   endtask

   task automatic t_w1c();
      wr(A_STAT, 32'h0000_0002);
      rd_chk("R3 clear one bit", A_STAT, 32'h11);
      wr(A_STAT, 32'h0000_0000);
      rd_chk("R3 write zero no change", A_STAT, 32'h11);
      wr(A_STAT, 32'hFFFF_FFFF);
      rd_chk("R3 clear all", A_STAT, 32'h0);
   endtask

   task automatic t_evt_wins();
      pulse(8'h01);
      @(negedge clk);
      src_evt = 8'h04; wr_en = 1'b1; addr = A_STAT; wr_data = 32'h05;
      @(posedge clk); #1;
      src_evt = '0; wr_en = 1'b0;
      rd_chk("R4 event wins, other bit cleared", A_STAT, 32'h04);
      wr(A_STAT, 32'hFF);
   endtask

   task automatic t_fields();
      wr(A_EN, 32'hFFFF_FF5A);
      rd_chk("R6 enable readback", A_EN, 32'h5A);
      wr(A_GIE, 32'h7FFF_FFFF);
      rd_chk("R7 gie only bit31", A_GIE, 32'h0);
      wr(A_GIE, 32'h8000_0000);
      rd_chk("R7 gie set", A_GIE, 32'h8000_0000);
      rd_chk("R11 unmapped", 8'h24, 32'h0);
      rd_chk("R11 reset reg reads zero", A_RST, 32'h0);
   endtask

   task automatic t_irq();
      wr(A_EN, 32'h01);
      wr(A_GIE, 32'h8000_0000);
      pulse(8'h08);   // masked source
      idle(1);
      check("R5 masked source no irq", {31'b0, irq_out}, 32'h0);
      pulse(8'h01);
      check("R5 irq not yet", {31'b0, irq_out}, 32'h0);
      idle(1);
      check("R5 irq rises", {31'b0, irq_out}, 32'h1);
      wr(A_GIE, 32'h0);
      check("R5 irq held one edge", {31'b0, irq_out}, 32'h1);
      idle(1);
      check("R5 gie gates irq", {31'b0, irq_out}, 32'h0);
      wr(A_GIE, 32'h8000_0000);
      idle(1);
      check("R5 irq back with gie", {31'b0, irq_out}, 32'h1);
      wr(A_STAT, 32'h01);
      idle(1);
      check("R5 irq drops after clear", {31'b0, irq_out}, 32'h0);
      wr(A_STAT, 32'hFF);
   endtask

   task automatic t_bad_key();
      wr(A_EN, 32'h3C);
      pulse(8'h20);
      wr(A_RST, 32'h0000_0005);
      check("R10 key_err pulse", {31'b0, key_err}, 32'h1);
      check("R10 no reset", {31'b0, core_rst}, 32'h0);
      idle(1);
      check("R10 key_err one cycle", {31'b0, key_err}, 32'h0);
      rd_chk("R10 enable kept", A_EN, 32'h3C);
      rd_chk("R10 status kept", A_STAT, 32'h20);
      wr(A_RST, 32'h0000_010A);
      check("R10 near-key rejected", {31'b0, key_err}, 32'h1);
   endtask

   task automatic t_soft_reset();
      int n;
      wr(A_EN, 32'hFF);
      wr(A_GIE, 32'h8000_0000);
      pulse(8'h81);
      idle(1);
      check("R9 irq before reset", {31'b0, irq_out}, 32'h1);
      wr(A_RST, 32'h0000_000A);
      check("R9 irq cleared", {31'b0, irq_out}, 32'h0);
      rd_chk("R9 status cleared", A_STAT, 32'h0);
      rd_chk("R9 enable cleared", A_EN, 32'h0);
      rd_chk("R9 gie cleared", A_GIE, 32'h0);
      check("R10 no key_err on key", {31'b0, key_err}, 32'h0);
      n = 0;
      while (core_rst && n < 100) begin
         n++;
         src_evt = (n == 3) ? 8'hFF : 8'h00;
         wr_en = (n == 4); addr = A_EN; wr_data = 32'hFF;
         @(posedge clk); #1;
      end
      src_evt = '0; wr_en = 1'b0;
      check("R8 pulse length", n, 16);
      rd_chk("R9 events ignored in reset", A_STAT, 32'h0);
      rd_chk("R9 writes ignored in reset", A_EN, 32'h0);
      wr(A_EN, 32'h11);
      rd_chk("R6 writes accepted after reset", A_EN, 32'h11);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         summary();
      end
   end

   initial begin
      idle(3);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset_state();
      t_sticky();
      t_w1c();
      t_evt_wins();
      t_fields();
      t_irq();
      t_bad_key();
      t_soft_reset();
      done = 1'b1;
      summary();
   end

endmodule